// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds three tables of two-bit saturating counters and reads all three at once for each lookup. The first is a per-address table indexed by low program-counter bits. The second is a correlating table whose index is those same bits XORed with a global shift register of recent branch outcomes. The third is a chooser table, indexed like the first. For each branch it decides which of the other two predictions is given to the fetch logic.

Lookup is combinational. The fetch stage presents a PC and gets back the final guess and both component guesses. When the branch resolves, the back end presents the PC, the real outcome and the two component guesses it captured at lookup. On that clock edge both component counters are trained. The chooser is trained only if the components disagreed. The outcome is then shifted into the global history. The correlating index used for that update is built from the history as it stood before the shift. That value matches the lookup-time history when lookups and updates are kept in order.

Top module: `tourPredictor`

## Requirements
- R1: After reset every component counter holds 01 (weak not-taken), every chooser holds 01 (weak prefer-per-address), and the global history is all zeros, so all three lookup outputs read 0 (not taken).
- R2: The per-address index is the field `pc[PC_LSB+IDX_W-1:PC_LSB]`. `lkBimPred` is bit 1 (the MSB) of the counter at that index.
- R3: The correlating index is the per-address index XORed with the global history, zero-extended to IDX_W bits. `lkGshPred` is the MSB of the counter at that index.
- R4: On each update both component counters are trained, whatever the chooser selected. A taken outcome increments a counter and saturates at 11. A not-taken outcome decrements it and saturates at 00. The correlating counter is addressed with the history from before this update's shift.
- R5: The final prediction `lkPred` equals `lkGshPred` when the chooser MSB is 1 and `lkBimPred` when it is 0.
- R6: The chooser entry changes only when `updBimPred` differs from `updGshPred`. It then increments, saturating at 11, if `updGshPred` matched the outcome, and decrements, saturating at 00, if `updBimPred` matched it.
- R7: Each update shifts the history left by one and puts the outcome (1 = taken) in bit 0. Without an update the history holds its value.
- R8: The lookup outputs depend only on `lkPc` and the stored state. An update presented in the same cycle affects lookups only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| lkPc | input | PC_W | Lookup program counter |
| lkPred | output | 1 | Final direction guess, 1 = taken |
| lkBimPred | output | 1 | Per-address component guess |
| lkGshPred | output | 1 | Correlating component guess |
| updValid | input | 1 | Update strobe for one resolved branch |
| updPc | input | PC_W | PC of the resolved branch |
| updTaken | input | 1 | Resolved outcome, 1 = taken |
| updBimPred | input | 1 | Per-address guess captured at lookup |
| updGshPred | input | 1 | Correlating guess captured at lookup |

## Verification
The bench drives counters into both saturation limits and checks that a fourth taken or not-taken outcome does not wrap. A design with a wrapping counter would flip its guess on a strongly biased branch. It also supplies component guesses that agree while the outcome contradicts them, to catch a chooser that moves without a disagreement. It supplies deliberately disagreeing guesses to check which way the chooser moves. A design that swapped the chooser direction, or that indexed the correlating table with the history after the shift, would drift from the reference model within a few random updates. A same-cycle lookup and update checks that no written value reaches the lookup before the clock edge.

// File: rtl/tourPredPkg.sv
package tourPredPkg;

  typedef struct packed {
    logic wrBim;      // train per-address counter
    logic wrGsh;      // train correlating counter
    logic wrSel;      // train chooser
    logic selUp;      // chooser direction: 1 = toward correlating
    logic shiftHist;  // shift outcome into history
    logic taken;      // resolved outcome
  } predCtl_t;

  function automatic logic [1:0] ctrStep(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

endpackage

// File: rtl/predCtrl.sv
module predCtrl
  import tourPredPkg::*;
(
  input  logic     updValid,
  input  logic     updTaken,
  input  logic     updBimPred,
  input  logic     updGshPred,
  input  logic     lkBim,
  input  logic     lkGsh,
  input  logic     lkSelMsb,
  output predCtl_t ctl,
  output logic     lkPred
);

  always_comb begin
    ctl.wrBim     = updValid;
    ctl.wrGsh     = updValid;
    ctl.wrSel     = updValid && (updBimPred != updGshPred);
    ctl.selUp     = (updGshPred == updTaken);
    ctl.shiftHist = updValid;
    ctl.taken     = updTaken;
  end

  assign lkPred = lkSelMsb ? lkGsh : lkBim;

endmodule

// File: rtl/predDatapath.sv
module predDatapath
  import tourPredPkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  predCtl_t          ctl,
  input  logic [PC_W-1:0]   lkPc,
  input  logic [PC_W-1:0]   updPc,
  output logic              lkBim,
  output logic              lkGsh,
  output logic              lkSelMsb,
  output logic [HIST_W-1:0] histQ
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0] bimTab [ENTRIES];
  logic [1:0] gshTab [ENTRIES];
  logic [1:0] selTab [ENTRIES];

  logic [IDX_W-1:0] lkIdx, lkGIdx, upIdx, upGIdx;

  assign lkIdx  = lkPc[PC_LSB +: IDX_W];
  assign upIdx  = updPc[PC_LSB +: IDX_W];
  assign lkGIdx = lkIdx ^ IDX_W'(histQ);
  assign upGIdx = upIdx ^ IDX_W'(histQ);

  logic unusedPcBits;
  assign unusedPcBits = ^{lkPc[PC_W-1:PC_LSB+IDX_W], lkPc[PC_LSB-1:0],
                          updPc[PC_W-1:PC_LSB+IDX_W], updPc[PC_LSB-1:0]};

  assign lkBim    = bimTab[lkIdx][1];
  assign lkGsh    = gshTab[lkGIdx][1];
  assign lkSelMsb = selTab[lkIdx][1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        bimTab[i] <= 2'b01;
        gshTab[i] <= 2'b01;
        selTab[i] <= 2'b01;
      end
      histQ <= '0;
    end else begin
      if (ctl.wrBim) bimTab[upIdx]  <= ctrStep(bimTab[upIdx], ctl.taken);
      if (ctl.wrGsh) gshTab[upGIdx] <= ctrStep(gshTab[upGIdx], ctl.taken);
      if (ctl.wrSel) selTab[upIdx]  <= ctrStep(selTab[upIdx], ctl.selUp);
      if (ctl.shiftHist) histQ <= {histQ[HIST_W-2:0], ctl.taken};
    end
  end

endmodule

// File: rtl/tourPredictor.sv
module tourPredictor
  import tourPredPkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lkPc,
  output logic            lkPred,
  output logic            lkBimPred,
  output logic            lkGshPred,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic            updBimPred,
  input  logic            updGshPred
);

  predCtl_t          ctl;
  logic              lkSelMsb;
  logic [HIST_W-1:0] histQ;

  predCtrl u_ctrl (
    .updValid  (updValid),
    .updTaken  (updTaken),
    .updBimPred(updBimPred),
    .updGshPred(updGshPred),
    .lkBim     (lkBimPred),
    .lkGsh     (lkGshPred),
    .lkSelMsb  (lkSelMsb),
    .ctl       (ctl),
    .lkPred    (lkPred)
  );

  predDatapath #(
    .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .lkPc    (lkPc),
    .updPc   (updPc),
    .lkBim   (lkBimPred),
    .lkGsh   (lkGshPred),
    .lkSelMsb(lkSelMsb),
    .histQ   (histQ)
  );

endmodule

// File: rtl/tourPredictorChk.sv
module tourPredictorChk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [PC_W-1:0]   lkPc,
  input logic              lkPred,
  input logic              lkBimPred,
  input logic              lkGshPred,
  input logic              updValid,
  input logic              updTaken,
  input logic [HIST_W-1:0] histQ
);

  assert_hist_reset_R1: assert property (@(posedge clk)
    $rose(rstN) |-> histQ == '0);

  assert_pick_agree_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lkBimPred == lkGshPred) |-> (lkPred == lkBimPred));

  assert_hist_shift_R7: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> histQ == {$past(histQ[HIST_W-2:0]), $past(updTaken)});

  assert_hist_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(histQ));

  assert_quiet_lookup_R8: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> (!$stable(lkPc) || $stable(lkPred)));

endmodule

bind tourPredictor tourPredictorChk #(.PC_W(PC_W), .HIST_W(HIST_W)) i_chk (
  .clk(clk), .rstN(rstN), .lkPc(lkPc), .lkPred(lkPred),
  .lkBimPred(lkBimPred), .lkGshPred(lkGshPred),
  .updValid(updValid), .updTaken(updTaken), .histQ(histQ)
);

// File: tb/test_tourPredictor.sv
module test_tourPredictor;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32, PC_LSB = 2, IDX_W = 6, HIST_W = 4;
  localparam int ENTRIES = 1 << IDX_W;

  logic clk = 0, rstN = 0;
  logic [PC_W-1:0] lkPc = '0, updPc = '0;
  logic lkPred, lkBimPred, lkGshPred;
  logic updValid = 0, updTaken = 0, updBimPred = 0, updGshPred = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0] mBim [ENTRIES];
  logic [1:0] mGsh [ENTRIES];
  logic [1:0] mSel [ENTRIES];
  logic [HIST_W-1:0] mHist;

  always #(CLK_PERIOD/2) clk = ~clk;

  tourPredictor #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W))
  i_tourPredictor (
    .clk(clk), .rstN(rstN), .lkPc(lkPc), .lkPred(lkPred),
    .lkBimPred(lkBimPred), .lkGshPred(lkGshPred), .updValid(updValid),
    .updPc(updPc), .updTaken(updTaken), .updBimPred(updBimPred),
    .updGshPred(updGshPred)
  );

  function automatic logic [1:0] sat(input logic [1:0] c, input bit up);
    if (up) return (c == 3) ? c : c + 1;
    return (c == 0) ? c : c - 1;
  endfunction

  function automatic int idxOf(input logic [PC_W-1:0] pc);
    return int'(pc[PC_LSB +: IDX_W]);
  endfunction

  function automatic int gIdxOf(input logic [PC_W-1:0] pc);
    return idxOf(pc) ^ int'(mHist);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Look up pc and compare all outputs to the model (R2 R3 R5).
  task automatic lookCheck(input logic [PC_W-1:0] pc);
    logic eb, eg;
    lkPc = pc;
    #1;
    eb = mBim[idxOf(pc)][1];
    eg = mGsh[gIdxOf(pc)][1];
    check(lkBimPred, eb, "R2 per-address guess");
    check(lkGshPred, eg, "R3 correlating guess");
    check(lkPred, mSel[idxOf(pc)][1] ? eg : eb, "R5 final choice");
  endtask

  // Apply one update with given captured guesses; model R4 R6 R7.
  task automatic doUpdate(input logic [PC_W-1:0] pc, input bit tk,
                          input bit bp, input bit gp);
    updValid = 1; updPc = pc; updTaken = tk; updBimPred = bp; updGshPred = gp;
    @(posedge clk);
    mBim[idxOf(pc)]  = sat(mBim[idxOf(pc)], tk);
    mGsh[gIdxOf(pc)] = sat(mGsh[gIdxOf(pc)], tk);
    if (bp != gp) mSel[idxOf(pc)] = sat(mSel[idxOf(pc)], gp == tk);
    mHist = {mHist[HIST_W-2:0], tk};
    @(negedge clk);
    updValid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] pcA, pcB, pcs [12];
    void'($urandom(32'd4242));
    for (int i = 0; i < ENTRIES; i++) begin
      mBim[i] = 2'b01; mGsh[i] = 2'b01; mSel[i] = 2'b01;
    end
    mHist = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1: reset state
    lkPc = 32'h0000_0040; #1;
    check(lkPred, 1'b0, "R1 reset final");
    check(lkBimPred, 1'b0, "R1 reset per-address");
    check(lkGshPred, 1'b0, "R1 reset correlating");

    // R4: saturate high then one not-taken keeps taken
    pcA = 32'h0000_0104;
    for (int k = 0; k < 4; k++) begin
      lookCheck(pcA);
      doUpdate(pcA, 1, lkBimPred, lkGshPred);
    end
    lookCheck(pcA);
    check(lkBimPred, 1'b1, "R4 saturated taken");
    doUpdate(pcA, 0, lkBimPred, lkGshPred);
    lookCheck(pcA);
    check(lkBimPred, 1'b1, "R4 no wrap after one not-taken");
    for (int k = 0; k < 5; k++) doUpdate(pcA, 0, 1, 1);
    lookCheck(pcA);
    check(lkBimPred, 1'b0, "R4 saturated not-taken");

    // R6: agreeing guesses never move chooser, disagreeing ones do
    pcB = 32'h0000_0208;
    for (int k = 0; k < 4; k++) doUpdate(pcB, 1, 0, 0);
    lookCheck(pcB);
    for (int k = 0; k < 2; k++) doUpdate(pcB, 1, 0, 1);
    lookCheck(pcB);
    for (int k = 0; k < 3; k++) doUpdate(pcB, 0, 0, 1);
    lookCheck(pcB);

    // R8: same-cycle update invisible until after the edge
    lkPc = pcA; updValid = 1; updPc = pcA; updTaken = 1;
    updBimPred = 0; updGshPred = 0; #1;
    check(lkBimPred, mBim[idxOf(pcA)][1], "R8 pre-edge lookup");
    updValid = 0;
    doUpdate(pcA, 1, 0, 0);
    lookCheck(pcA);

    // Random traffic (R2 R3 R4 R5 R6 R7)
    for (int k = 0; k < 12; k++) pcs[k] = {$urandom} & 32'h0000_0FFC;
    for (int it = 0; it < 1500; it++) begin
      logic [PC_W-1:0] pc;
      bit tk;
      int s;
      s  = int'($urandom % 12);
      pc = pcs[s];
      lookCheck(pc);
      if (s < 4)      tk = ($urandom % 8) != 0;
      else if (s < 8) tk = mHist[0] ^ mHist[1];
      else            tk = $urandom % 2;
      doUpdate(pc, tk, lkBimPred, lkGshPred);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule